// File: doc/BRIEF.md
# Serial Configuration Word Loader for a Dual Synthesizer

This block takes configuration words for two frequency synthesizer channels over a three-wire link: a serial clock, a serial data line and a load strobe. The three wires come from off-chip, so each one passes through a synchronizer into the system clock domain. The block then finds edges on them there. Every rising edge of the serial clock moves one data bit into a 23-bit shift register, most significant bit first.

When the load strobe rises, the two bits that arrived last act as an address. They pick one of four configuration latches: the reference latch or the counter latch, for channel 1 or channel 2. A reference word carries a 14-bit reference divide ratio, two test-select bits and a pump-current select bit. A counter word carries an 11-bit main divide ratio, a 7-bit swallow count, a modulus-select bit, a phase-polarity bit and a monitor-select bit.

A word is accepted only when exactly 23 serial clock edges have come in since the previous load strobe. Any other count raises an error flag and leaves every latch unchanged. Each latch also has a flag that shows it has received at least one valid word.

Top module: `serial_word_loader`

## Requirements
- R1: After reset, every latched field is zero, all eight written flags are low and `frameErr` is low.
- R2: Each synchronized rising edge of `serClk` shifts `serData` into a 23-bit register, most significant bit first. The bit sent last lands in word position 1 and the one before it in position 2. Positions are numbered 1 to 23 from the last bit received.
- R3: On a valid load, position 1 picks the channel (0 means channel 1, 1 means channel 2). Position 2 picks the latch kind (0 means reference latch, 1 means counter latch).
- R4: Layout of a reference word: position 3 is test bit 0, position 4 is test bit 1, positions 5 to 18 are the reference ratio with its LSB at position 5, and position 19 is the pump-current select. Positions 20 to 23 are ignored.
- R5: Layout of a counter word: position 3 is monitor-select, position 4 is modulus-select, position 5 is phase-polarity, positions 6 to 12 are the swallow count (LSB at 6), and positions 13 to 23 are the main ratio (LSB at 13).
- R6: A synchronized rising edge of `serLe` commits the word only if exactly 23 serial clock edges came in since the previous `serLe` rise or since reset. Any other count, including zero or 24, sets `frameErr` and changes no latch.
- R7: A valid load clears `frameErr`.
- R8: A latch's written flag goes high at its first valid load and stays high until reset.
- R9: A valid load changes only the selected latch. The other three latches and their written flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, asynchronous |
| serLe | input | 1 | Load strobe, asynchronous |
| refDiv | output | 2x14 | Reference divide ratio per channel |
| testSel | output | 2x2 | Test-select bits per channel (bit 0 from position 3) |
| pumpHigh | output | 2 | Pump-current select per channel |
| swallow | output | 2x7 | Swallow count per channel |
| mainDiv | output | 2x11 | Main divide ratio per channel |
| modSel | output | 2 | Modulus-select bit per channel |
| phasePol | output | 2 | Phase-polarity bit per channel |
| monSel | output | 2 | Monitor-select bit per channel |
| refWritten | output | 2 | Reference latch has been loaded, per channel |
| cntWritten | output | 2 | Counter latch has been loaded, per channel |
| frameErr | output | 1 | Last load strobe saw a wrong bit count |

## Verification
The assertions check several rules on every cycle. A load strobe with a wrong count must raise the error flag, and a commit must clear it. At most one latch may be selected in any cycle, and no latch may change without a commit. Written flags must never fall, and each shift must place the synchronized data bit at the bottom of the register. Only the bench scenarios can show the field placement of each word layout, the address decode to the right channel and latch, and that short frames, long frames and bare strobes leave all configuration untouched. The bench checks all of these against a model built from the requirements.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int WORD_W = 23;
  localparam int NUM_CH = 2;
  localparam int R_W = 14;
  localparam int A_W = 7;
  localparam int N_W = 11;
  localparam int T_W = 2;
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam int NUM_LATCH = 2 * NUM_CH;

  // bit indices inside the shift register (index = word position - 1)
  localparam int P_CH = 0;
  localparam int P_KIND = 1;
  localparam int P_T = 2;
  localparam int P_R = P_T + T_W;
  localparam int P_CS = P_R + R_W;
  localparam int P_LDS = 2;
  localparam int P_SW = 3;
  localparam int P_FC = 4;
  localparam int P_A = 5;
  localparam int P_N = P_A + A_W;

  typedef struct packed {
    logic shift;
    logic load;
  } strobe_t;
endpackage

// File: rtl/swl_sync.sv
module swl_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/swl_ctrl.sv
module swl_ctrl
  import swl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    clkS,
  input  logic    leS,
  output strobe_t stb,
  output logic    frameErr
);
  logic             clkPrev;
  logic             lePrev;
  logic [CNT_W-1:0] bitCnt;
  logic             clkRise;
  logic             leRise;
  logic             countOk;

  assign clkRise = clkS & ~clkPrev;
  assign leRise  = leS & ~lePrev;
  assign countOk = (bitCnt == CNT_W'(WORD_W));

  always_comb begin
    stb.shift = clkRise;
    stb.load  = leRise & countOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      lePrev   <= 1'b0;
      bitCnt   <= '0;
      frameErr <= 1'b0;
    end else begin
      clkPrev <= clkS;
      lePrev  <= leS;
      if (leRise) begin
        bitCnt   <= '0;
        frameErr <= ~countOk;
      end else if (clkRise && bitCnt != CNT_W'(WORD_W + 1)) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R6: a strobe seen with a wrong count must leave the error flag set
  a_r6_err_on_miscount: assert property (@(posedge clk) disable iff (!rstN)
    (leRise && !countOk) |=> frameErr);

  // R7: a commit clears the error flag
  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !frameErr);

  // R6: the error flag moves only on a load strobe
  a_r6_err_stable: assert property (@(posedge clk) disable iff (!rstN)
    !leRise |=> $stable(frameErr));
endmodule

// File: rtl/swl_datapath.sv
module swl_datapath
  import swl_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           dataS,
  input  strobe_t                        stb,
  output logic [NUM_CH-1:0][R_W-1:0]     refDiv,
  output logic [NUM_CH-1:0][T_W-1:0]     testSel,
  output logic [NUM_CH-1:0]              pumpHigh,
  output logic [NUM_CH-1:0][A_W-1:0]     swallow,
  output logic [NUM_CH-1:0][N_W-1:0]     mainDiv,
  output logic [NUM_CH-1:0]              modSel,
  output logic [NUM_CH-1:0]              phasePol,
  output logic [NUM_CH-1:0]              monSel,
  output logic [NUM_CH-1:0]              refWritten,
  output logic [NUM_CH-1:0]              cntWritten
);
  logic [WORD_W-1:0]    shiftReg;
  logic [NUM_LATCH-1:0] loadVec;

  always_ff @(posedge clk) begin
    if (!rstN)          shiftReg <= '0;
    else if (stb.shift) shiftReg <= {shiftReg[WORD_W-2:0], dataS};
  end

  // latch index = {kind, channel}: 0/1 reference, 2/3 counter
  always_comb begin
    loadVec = '0;
    if (stb.load) loadVec[{shiftReg[P_KIND], shiftReg[P_CH]}] = 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        refDiv[ch]     <= '0;
        testSel[ch]    <= '0;
        pumpHigh[ch]   <= 1'b0;
        refWritten[ch] <= 1'b0;
      end else if (loadVec[ch]) begin
        refDiv[ch]     <= shiftReg[P_R +: R_W];
        testSel[ch]    <= shiftReg[P_T +: T_W];
        pumpHigh[ch]   <= shiftReg[P_CS];
        refWritten[ch] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        swallow[ch]    <= '0;
        mainDiv[ch]    <= '0;
        modSel[ch]     <= 1'b0;
        phasePol[ch]   <= 1'b0;
        monSel[ch]     <= 1'b0;
        cntWritten[ch] <= 1'b0;
      end else if (loadVec[NUM_CH + ch]) begin
        swallow[ch]    <= shiftReg[P_A +: A_W];
        mainDiv[ch]    <= shiftReg[P_N +: N_W];
        modSel[ch]     <= shiftReg[P_SW];
        phasePol[ch]   <= shiftReg[P_FC];
        monSel[ch]     <= shiftReg[P_LDS];
        cntWritten[ch] <= 1'b1;
      end
    end

    // R8: written flags never fall once set
    a_r8_ref_sticky: assert property (@(posedge clk) disable iff (!rstN)
      refWritten[ch] |=> refWritten[ch]);
    a_r8_cnt_sticky: assert property (@(posedge clk) disable iff (!rstN)
      cntWritten[ch] |=> cntWritten[ch]);
  end

  // R9: at most one latch selected per cycle
  a_r9_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadVec));

  // R6: no latch moves without a commit strobe
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> ($stable(refDiv) && $stable(mainDiv) && $stable(swallow)
                   && $stable(testSel) && $stable(pumpHigh) && $stable(modSel)
                   && $stable(phasePol) && $stable(monSel)));

  // R2: the synchronized data bit enters at the bottom of the register
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> shiftReg[0] == $past(dataS));
endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader
  import swl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serClk,
  input  logic                       serData,
  input  logic                       serLe,
  output logic [NUM_CH-1:0][R_W-1:0] refDiv,
  output logic [NUM_CH-1:0][T_W-1:0] testSel,
  output logic [NUM_CH-1:0]          pumpHigh,
  output logic [NUM_CH-1:0][A_W-1:0] swallow,
  output logic [NUM_CH-1:0][N_W-1:0] mainDiv,
  output logic [NUM_CH-1:0]          modSel,
  output logic [NUM_CH-1:0]          phasePol,
  output logic [NUM_CH-1:0]          monSel,
  output logic [NUM_CH-1:0]          refWritten,
  output logic [NUM_CH-1:0]          cntWritten,
  output logic                       frameErr
);
  logic [2:0] syncBus;
  strobe_t    stb;

  swl_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({serLe, serData, serClk}),
    .syncOut (syncBus)
  );

  swl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkS     (syncBus[0]),
    .leS      (syncBus[2]),
    .stb      (stb),
    .frameErr (frameErr)
  );

  swl_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dataS      (syncBus[1]),
    .stb        (stb),
    .refDiv     (refDiv),
    .testSel    (testSel),
    .pumpHigh   (pumpHigh),
    .swallow    (swallow),
    .mainDiv    (mainDiv),
    .modSel     (modSel),
    .phasePol   (phasePol),
    .monSel     (monSel),
    .refWritten (refWritten),
    .cntWritten (cntWritten)
  );
endmodule

// File: tb/serial_word_loader_test.sv
module serial_word_loader_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serLe = 1'b0;
  logic [1:0][13:0] refDiv;
  logic [1:0][1:0]  testSel;
  logic [1:0]       pumpHigh;
  logic [1:0][6:0]  swallow;
  logic [1:0][10:0] mainDiv;
  logic [1:0]       modSel, phasePol, monSel, refWritten, cntWritten;
  logic             frameErr;

  always #4 clk = ~clk;

  serial_word_loader uut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLe(serLe),
    .refDiv(refDiv), .testSel(testSel), .pumpHigh(pumpHigh), .swallow(swallow),
    .mainDiv(mainDiv), .modSel(modSel), .phasePol(phasePol), .monSel(monSel),
    .refWritten(refWritten), .cntWritten(cntWritten), .frameErr(frameErr)
  );

  typedef struct {
    int    rDiv[2]; int tSel[2]; int pump[2];
    int    sw[2];   int nDiv[2]; int mod[2]; int pol[2]; int mon[2];
    int    refW[2]; int cntW[2]; int err;
    string tag;
  } exp_t;

  exp_t model;
  exp_t expQ[$];
  event chk;
  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic cmp(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected snapshots and compares against the ports
  initial begin
    forever begin
      @(chk);
      @(negedge clk);
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        for (int c = 0; c < 2; c++) begin
          cmp({e.tag, "/R4"}, $sformatf("refDiv[%0d]", c), int'(refDiv[c]), e.rDiv[c]);
          cmp({e.tag, "/R4"}, $sformatf("testSel[%0d]", c), int'(testSel[c]), e.tSel[c]);
          cmp({e.tag, "/R4"}, $sformatf("pumpHigh[%0d]", c), int'(pumpHigh[c]), e.pump[c]);
          cmp({e.tag, "/R5"}, $sformatf("swallow[%0d]", c), int'(swallow[c]), e.sw[c]);
          cmp({e.tag, "/R5"}, $sformatf("mainDiv[%0d]", c), int'(mainDiv[c]), e.nDiv[c]);
          cmp({e.tag, "/R5"}, $sformatf("modSel[%0d]", c), int'(modSel[c]), e.mod[c]);
          cmp({e.tag, "/R5"}, $sformatf("phasePol[%0d]", c), int'(phasePol[c]), e.pol[c]);
          cmp({e.tag, "/R5"}, $sformatf("monSel[%0d]", c), int'(monSel[c]), e.mon[c]);
          cmp({e.tag, "/R8"}, $sformatf("refWritten[%0d]", c), int'(refWritten[c]), e.refW[c]);
          cmp({e.tag, "/R8"}, $sformatf("cntWritten[%0d]", c), int'(cntWritten[c]), e.cntW[c]);
        end
        cmp({e.tag, "/R6"}, "frameErr", int'(frameErr), e.err);
      end
    end
  end

  // word builders from the R4/R5 layouts (index = position - 1)
  function automatic logic [22:0] refWord(int ch, logic [1:0] t, logic [13:0] r, logic cs);
    logic [22:0] w;
    w = '0;
    w[0] = ch[0]; w[1] = 1'b0;            // R3: position 1 channel, 2 kind
    w[2] = t[0]; w[3] = t[1];
    w[17:4] = r; w[18] = cs;
    w[22:19] = 4'b1011;                   // ignored bits, R4
    return w;
  endfunction

  function automatic logic [22:0] cntWord(int ch, logic lds, logic sw, logic fc,
                                          logic [6:0] a, logic [10:0] n);
    logic [22:0] w;
    w = '0;
    w[0] = ch[0]; w[1] = 1'b1;
    w[2] = lds; w[3] = sw; w[4] = fc;
    w[11:5] = a; w[22:12] = n;
    return w;
  endfunction

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: sends nBits (MSB first, R2), pulses the strobe, pushes expectation
  task automatic sendFrame(logic [22:0] w, int nBits, string tag);
    for (int i = nBits - 1; i >= 0; i--) begin
      @(negedge clk);
      serData = (i < 23) ? w[i] : 1'b0;
      waitClk(3);
      serClk = 1'b1;
      waitClk(4);
      serClk = 1'b0;
      waitClk(3);
    end
    waitClk(4);
    serLe = 1'b1;
    waitClk(6);
    serLe = 1'b0;
    waitClk(8);
    if (nBits == 23) begin
      int ch;
      ch = int'(w[0]);
      if (!w[1]) begin
        model.rDiv[ch] = int'(w[17:4]);
        model.tSel[ch] = int'({w[3], w[2]});
        model.pump[ch] = int'(w[18]);
        model.refW[ch] = 1;
      end else begin
        model.sw[ch]   = int'(w[11:5]);
        model.nDiv[ch] = int'(w[22:12]);
        model.mod[ch]  = int'(w[3]);
        model.pol[ch]  = int'(w[4]);
        model.mon[ch]  = int'(w[2]);
        model.cntW[ch] = 1;
      end
      model.err = 0;
    end else begin
      model.err = 1;
    end
    model.tag = tag;
    expQ.push_back(model);
    ->chk;
    waitClk(3);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      model.rDiv[c] = 0; model.tSel[c] = 0; model.pump[c] = 0;
      model.sw[c] = 0; model.nDiv[c] = 0; model.mod[c] = 0;
      model.pol[c] = 0; model.mon[c] = 0; model.refW[c] = 0; model.cntW[c] = 0;
    end
    model.err = 0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    model.tag = "R1";                     // reset state
    expQ.push_back(model);
    ->chk;
    waitClk(3);
    // R2 R3 R4: reference word channel 1
    sendFrame(refWord(0, 2'b10, 14'd3, 1'b1), 23, "R2_R3");
    // R3 R9: reference word channel 2 leaves channel 1 alone
    sendFrame(refWord(1, 2'b01, 14'd16383, 1'b0), 23, "R9");
    // R5: counter word channel 1
    sendFrame(cntWord(0, 1'b1, 1'b0, 1'b1, 7'd127, 11'd3), 23, "R5");
    // R5 R9: counter word channel 2
    sendFrame(cntWord(1, 1'b0, 1'b1, 1'b0, 7'd0, 11'd2047), 23, "R9");
    // R6: short frame changes nothing, sets error
    sendFrame(refWord(0, 2'b11, 14'h1555, 1'b0), 22, "R6_short");
    // R7: good frame clears the error
    sendFrame(cntWord(0, 1'b0, 1'b1, 1'b1, 7'd85, 11'd1234), 23, "R7");
    // R6: long frame rejected
    sendFrame(cntWord(1, 1'b1, 1'b1, 1'b1, 7'd1, 11'd1), 24, "R6_long");
    // R6: bare strobe with no clocks
    sendFrame('0, 0, "R6_bare");
    // R7 R8: overwrite channel 1 reference after errors
    sendFrame(refWord(0, 2'b00, 14'h2AAA, 1'b0), 23, "R7_R8");
    waitClk(5);
    done = 1;
  end

  initial begin
    for (int cyc = 0; cyc < 150000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule